// File: doc/BRIEF.md
# Subroutine and Break Control Sequencer

This block steps the 64-bit program counter through the four control transfers that touch the stack: subroutine call, subroutine return, break, and return from interrupt. It also loads the starting PC after reset. It owns the PC, a 16-bit stack pointer and a bank of per-thread status bytes. It reaches memory through one byte-wide port, which serves operand fetches, stack pushes, stack pulls and vector fetches, one byte per clock.

An operation is started by `req_valid` with an operation code and a thread index while `busy` is low. The PC must point at the first byte after the opcode when the operation is requested. `busy` stays high from the cycle after acceptance until the final commit cycle. PC, SP and status change only in that commit cycle. Stack bytes sit at `STACK_BASE + sp`. A push writes at SP and moves SP down. A pull moves SP up and then reads. Both vectors are split into a low 32-bit half and a high 32-bit half held at two separate address ranges.

Top module: `subr_seq`

## Requirements
- R1: While reset is high and until the boot sequence ends, `busy` is 1. The boot sequence then sets PC bits 31:0 from bytes 0xFFC0..0xFFC3 and bits 63:32 from bytes 0xFFD0..0xFFD3, with the lowest address holding the least significant byte. It also sets SP to `SP_INIT` (0x8000) and all status lanes to 0.
- R2: Call (`req_op`=0) reads 8 bytes at PC..PC+7 as a little-endian target and then sets PC to that target.
- R3: Call writes PC+8 to the stack as 8 bytes, most significant byte first, at addresses `STACK_BASE`+SP, SP-1, …, SP-7. SP then decreases by 8.
- R4: Return (`req_op`=1) reads bytes at `STACK_BASE`+SP+1 … SP+8 as the least significant byte up to the most significant byte, and sets PC to that value plus 1. SP increases by 8. A call followed by a return therefore leaves PC at the call's operand address plus 9.
- R5: Break (`req_op`=2) writes PC-1 as 8 bytes, most significant first, at SP down to SP-7. It then writes byte `status[8*thread+7:8*thread]` at SP-8. SP decreases by 9.
- R6: Break sets bit 2 (interrupt disable) of the requesting thread's status lane and leaves every other lane unchanged.
- R7: Break sets PC bits 31:0 from bytes 0xFFE0..0xFFE3 and bits 63:32 from bytes 0xFFF0..0xFFF3, with the lowest address holding the least significant byte.
- R8: Return from interrupt (`req_op`=3) first reads the byte at SP+1 and places it in the requesting thread's status lane. It then reads the PC from SP+2..SP+9 exactly as a return does, including the +1. SP increases by 9. Other lanes are unchanged.
- R9: One memory access is made per busy cycle, never a read and a write together, and none while idle. `busy` lasts the number of accesses plus one cycle: call 17, return 9, break 18, return from interrupt 10, boot 9. PC, SP and status change only when `busy` falls.
- R10: A request raised while `busy` is 1 has no effect on the running sequence, its accesses or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the boot sequence |
| req_valid | input | 1 | Operation request, taken only while busy is low |
| req_op | input | 2 | 0 call, 1 return, 2 break, 3 return from interrupt |
| req_thread | input | 3 | Thread whose status lane the operation uses |
| busy | output | 1 | A sequence is in progress |
| pc | output | 64 | Program counter |
| sp | output | 16 | Stack pointer |
| status | output | 64 | Eight status lanes, lane t at bits 8t+7:8t |
| mem_rd | output | 1 | Byte read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid within the cycle the read address is presented |

## Verification
The assertions assume that `mem_rdata` settles within the cycle the address is presented. They also assume that reset is applied before any request, so that the reset values are the first history the PC, SP and status checks see. The bench memory refreshes read data on the falling edge, and it drives requests only on falling edges. Random targets and break vectors keep their top bit set, so code addresses never land in the stack region that the write-range property guards. Random requests raised during busy sequences check that stray requests leave the sequence untouched.

// File: rtl/subr_seq_pkg.sv
package subr_seq_pkg;

  typedef enum logic [2:0] {
    OP_CALL = 3'd0,
    OP_RET  = 3'd1,
    OP_BRK  = 3'd2,
    OP_RTI  = 3'd3,
    OP_BOOT = 3'd4
  } seq_op_e;

  typedef enum logic [1:0] {
    ROLE_NONE,
    ROLE_DATA,
    ROLE_STAT
  } role_e;

  typedef enum logic [1:0] {
    S_BOOT,
    S_IDLE,
    S_RUN,
    S_DONE
  } seq_state_e;

  // Number of byte accesses each sequence makes, nb = bytes per PC.
  function automatic int unsigned seq_accesses(seq_op_e op, int unsigned nb);
    case (op)
      OP_CALL: return 2 * nb;
      OP_RET:  return nb;
      OP_BRK:  return 2 * nb + 1;
      OP_RTI:  return nb + 1;
      default: return nb;
    endcase
  endfunction

endpackage

// File: rtl/subr_seq_plan.sv
module subr_seq_plan
  import subr_seq_pkg::*;
#(
  parameter int PC_W = 64,
  parameter int SP_W = 16,
  parameter logic [PC_W-1:0] STACK_BASE  = 64'h0000_0000_0001_0000,
  parameter logic [PC_W-1:0] VEC_BRK_LO  = 64'hFFE0,
  parameter logic [PC_W-1:0] VEC_BRK_HI  = 64'hFFF0,
  parameter logic [PC_W-1:0] VEC_BOOT_LO = 64'hFFC0,
  parameter logic [PC_W-1:0] VEC_BOOT_HI = 64'hFFD0
) (
  input  seq_op_e               op,
  input  logic [$clog2(2*(PC_W/8)+2)-1:0] step,
  input  logic [PC_W-1:0]       pc,
  input  logic [SP_W-1:0]       sp,
  input  logic [7:0]            lane_byte,
  output logic                  acc_rd,
  output logic                  acc_wr,
  output logic [PC_W-1:0]       acc_addr,
  output logic [7:0]            acc_wdata,
  output role_e                 acc_role,
  output logic [$clog2(PC_W/8)-1:0] acc_idx
);
  localparam int NB   = PC_W / 8;
  localparam int HALF = NB / 2;
  localparam int IW   = $clog2(NB);

  function automatic logic [7:0] byte_of(logic [PC_W-1:0] v, logic [IW-1:0] b);
    return v[8*b +: 8];
  endfunction

  function automatic logic [PC_W-1:0] stack_addr(logic [SP_W-1:0] s);
    return STACK_BASE + PC_W'(s);
  endfunction

  function automatic logic [PC_W-1:0] vec_addr(logic [PC_W-1:0] lo, logic [PC_W-1:0] hi,
                                               int unsigned k);
    return (k < HALF) ? lo + PC_W'(k) : hi + PC_W'(k - HALF);
  endfunction

  always_comb begin
    int unsigned s;
    s         = int'(step);
    acc_rd    = 1'b0;
    acc_wr    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    acc_role  = ROLE_NONE;
    acc_idx   = '0;
    case (op)
      OP_CALL: begin
        if (s < NB) begin
          acc_rd   = 1'b1;
          acc_addr = pc + PC_W'(s);
          acc_role = ROLE_DATA;
          acc_idx  = IW'(s);
        end else begin
          acc_wr    = 1'b1;
          acc_addr  = stack_addr(sp - SP_W'(s - NB));
          acc_wdata = byte_of(pc + PC_W'(NB), IW'(NB - 1 - (s - NB)));
        end
      end
      OP_RET: begin
        acc_rd   = 1'b1;
        acc_addr = stack_addr(sp + SP_W'(s + 1));
        acc_role = ROLE_DATA;
        acc_idx  = IW'(s);
      end
      OP_BRK: begin
        if (s < NB) begin
          acc_wr    = 1'b1;
          acc_addr  = stack_addr(sp - SP_W'(s));
          acc_wdata = byte_of(pc - PC_W'(1), IW'(NB - 1 - s));
        end else if (s == NB) begin
          acc_wr    = 1'b1;
          acc_addr  = stack_addr(sp - SP_W'(NB));
          acc_wdata = lane_byte;
        end else begin
          acc_rd   = 1'b1;
          acc_addr = vec_addr(VEC_BRK_LO, VEC_BRK_HI, s - NB - 1);
          acc_role = ROLE_DATA;
          acc_idx  = IW'(s - NB - 1);
        end
      end
      OP_RTI: begin
        acc_rd = 1'b1;
        if (s == 0) begin
          acc_addr = stack_addr(sp + SP_W'(1));
          acc_role = ROLE_STAT;
        end else begin
          acc_addr = stack_addr(sp + SP_W'(s + 1));
          acc_role = ROLE_DATA;
          acc_idx  = IW'(s - 1);
        end
      end
      default: begin
        acc_rd   = 1'b1;
        acc_addr = vec_addr(VEC_BOOT_LO, VEC_BOOT_HI, s);
        acc_role = ROLE_DATA;
        acc_idx  = IW'(s);
      end
    endcase
  end

endmodule

// File: rtl/subr_seq_gather.sv
module subr_seq_gather
  import subr_seq_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      cap,
  input  role_e                     role,
  input  logic [$clog2(PC_W/8)-1:0] idx,
  input  logic [7:0]                rdata,
  output logic [PC_W-1:0]           word,
  output logic [7:0]                stat_byte
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word      <= '0;
      stat_byte <= '0;
    end else if (cap) begin
      if (role == ROLE_DATA) word[8*idx +: 8] <= rdata;
      else if (role == ROLE_STAT) stat_byte <= rdata;
    end
  end
endmodule

// File: rtl/subr_seq_lanes.sv
module subr_seq_lanes #(
  parameter int THREADS  = 8,
  parameter int IDIS_BIT = 2,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_idis,
  input  logic                   load,
  input  logic [TW-1:0]          thr,
  input  logic [7:0]             lane_in,
  output logic [THREADS*8-1:0]   status,
  output logic [7:0]             cur_lane
);
  logic [7:0] lane_q [THREADS];

  for (genvar g = 0; g < THREADS; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_q[g] <= '0;
      else if (thr == TW'(g)) begin
        if (load) lane_q[g] <= lane_in;
        else if (set_idis) lane_q[g][IDIS_BIT] <= 1'b1;
      end
    end
    assign status[8*g +: 8] = lane_q[g];
  end

  assign cur_lane = lane_q[thr];
endmodule

// File: rtl/subr_seq.sv
module subr_seq
  import subr_seq_pkg::*;
#(
  parameter int PC_W     = 64,
  parameter int SP_W     = 16,
  parameter int THREADS  = 8,
  parameter int IDIS_BIT = 2,
  parameter logic [SP_W-1:0] SP_INIT     = 16'h8000,
  parameter logic [PC_W-1:0] STACK_BASE  = 64'h0000_0000_0001_0000,
  parameter logic [PC_W-1:0] VEC_BRK_LO  = 64'hFFE0,
  parameter logic [PC_W-1:0] VEC_BRK_HI  = 64'hFFF0,
  parameter logic [PC_W-1:0] VEC_BOOT_LO = 64'hFFC0,
  parameter logic [PC_W-1:0] VEC_BOOT_HI = 64'hFFD0,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [TW-1:0]        req_thread,
  output logic                 busy,
  output logic [PC_W-1:0]      pc,
  output logic [SP_W-1:0]      sp,
  output logic [THREADS*8-1:0] status,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [PC_W-1:0]      mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata
);
  localparam int NB = PC_W / 8;
  localparam int SW = $clog2(2 * NB + 2);
  localparam int IW = $clog2(NB);

  seq_state_e      st;
  seq_op_e         op_q, op_sel;
  logic [TW-1:0]   thr_q;
  logic [SW-1:0]   step_q, step_sel, last_s;
  role_e           role_q, p_role;
  logic [IW-1:0]   idx_q, p_idx;
  logic            p_rd, p_wr, present;
  logic [PC_W-1:0] p_addr, word;
  logic [7:0]      p_wdata, stat_byte, cur_lane;

  assign op_sel   = (st == S_IDLE) ? seq_op_e'({1'b0, req_op}) : op_q;
  assign step_sel = (st == S_RUN) ? step_q + SW'(1) : '0;
  assign last_s   = SW'(seq_accesses(op_q, NB) - 1);
  assign present  = (st == S_BOOT) || (st == S_IDLE && req_valid) ||
                    (st == S_RUN && step_q != last_s);

  subr_seq_plan #(
    .PC_W(PC_W), .SP_W(SP_W), .STACK_BASE(STACK_BASE),
    .VEC_BRK_LO(VEC_BRK_LO), .VEC_BRK_HI(VEC_BRK_HI),
    .VEC_BOOT_LO(VEC_BOOT_LO), .VEC_BOOT_HI(VEC_BOOT_HI)
  ) u_plan (
    .op(op_sel), .step(step_sel), .pc(pc), .sp(sp), .lane_byte(cur_lane),
    .acc_rd(p_rd), .acc_wr(p_wr), .acc_addr(p_addr), .acc_wdata(p_wdata),
    .acc_role(p_role), .acc_idx(p_idx)
  );

  subr_seq_gather #(.PC_W(PC_W)) u_gather (
    .clk(clk), .rst(rst), .clr(st == S_IDLE || st == S_BOOT), .cap(st == S_RUN),
    .role(role_q), .idx(idx_q), .rdata(mem_rdata), .word(word), .stat_byte(stat_byte)
  );

  subr_seq_lanes #(.THREADS(THREADS), .IDIS_BIT(IDIS_BIT)) u_lanes (
    .clk(clk), .rst(rst),
    .set_idis(st == S_DONE && op_q == OP_BRK),
    .load(st == S_DONE && op_q == OP_RTI),
    .thr(thr_q), .lane_in(stat_byte), .status(status), .cur_lane(cur_lane)
  );

  // Registered memory port: one access per cycle.
  always_ff @(posedge clk) begin
    if (rst || !present) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      role_q    <= ROLE_NONE;
      idx_q     <= '0;
    end else begin
      mem_rd    <= p_rd;
      mem_wr    <= p_wr;
      mem_addr  <= p_addr;
      mem_wdata <= p_wdata;
      role_q    <= p_role;
      idx_q     <= p_idx;
    end
  end

  // Sequence control and commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_BOOT;
      busy   <= 1'b1;
      op_q   <= OP_BOOT;
      thr_q  <= '0;
      step_q <= '0;
      pc     <= '0;
      sp     <= SP_INIT;
    end else begin
      case (st)
        S_BOOT: begin
          st     <= S_RUN;
          step_q <= '0;
        end
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= op_sel;
            thr_q  <= req_thread;
            step_q <= '0;
            busy   <= 1'b1;
            st     <= S_RUN;
          end
        end
        S_RUN: begin
          if (step_q == last_s) st <= S_DONE;
          else step_q <= step_q + SW'(1);
        end
        S_DONE: begin
          busy <= 1'b0;
          st   <= S_IDLE;
          case (op_q)
            OP_CALL: begin pc <= word;              sp <= sp - SP_W'(NB);     end
            OP_RET:  begin pc <= word + PC_W'(1);   sp <= sp + SP_W'(NB);     end
            OP_BRK:  begin pc <= word;              sp <= sp - SP_W'(NB + 1); end
            OP_RTI:  begin pc <= word + PC_W'(1);   sp <= sp + SP_W'(NB + 1); end
            default: pc <= word;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/subr_seq_chk.sv
module subr_seq_chk #(
  parameter int PC_W    = 64,
  parameter int SP_W    = 16,
  parameter int THREADS = 8,
  parameter logic [PC_W-1:0] STACK_BASE = 64'h0000_0000_0001_0000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 busy,
  input logic [PC_W-1:0]      pc,
  input logic [SP_W-1:0]      sp,
  input logic [THREADS*8-1:0] status,
  input logic                 mem_rd,
  input logic                 mem_wr,
  input logic [PC_W-1:0]      mem_addr
);
  logic [PC_W-1:0] wr_off;
  assign wr_off = mem_addr - STACK_BASE;

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));  // R9
  AST_PC_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> $fell(busy));  // R9
  AST_SP_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> $fell(busy));  // R9
  AST_STATUS_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> $fell(busy));  // R6
  AST_PUSH_IN_STACK: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ((wr_off >> SP_W) == '0));  // R3
  AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);  // R10
endmodule

bind subr_seq subr_seq_chk #(
  .PC_W(PC_W), .SP_W(SP_W), .THREADS(THREADS), .STACK_BASE(STACK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .pc(pc), .sp(sp),
  .status(status), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/sim_subr_seq.sv
`timescale 1ns/1ps
module sim_subr_seq;
  localparam logic [63:0] SB = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [2:0]  req_thread;
  logic        busy;
  logic [63:0] pc;
  logic [15:0] sp;
  logic [63:0] status;
  logic        mem_rd, mem_wr;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  always #2.5 clk = ~clk;

  subr_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_thread(req_thread), .busy(busy), .pc(pc), .sp(sp), .status(status),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [logic [63:0]];
  function automatic logic [7:0] mget(logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction
  function automatic logic [63:0] stk(logic [15:0] s);
    return SB + {48'd0, s};
  endfunction

  always @(negedge clk) mem_rdata <= mget(mem_addr);

  logic [63:0] wa [16];
  logic [7:0]  wd [16];
  int wn, rn;
  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr] = mem_wdata;
      if (wn < 16) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
      wn++;
    end
    if (mem_rd) rn++;
  end

  int pass_n = 0, fail_n = 0;
  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    if (act === exp) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [63:0] pc_m, st_m;
  logic [15:0] sp_m;

  task automatic issue(input logic [1:0] op, input logic [2:0] thr, input bit inject,
                       output int cyc);
    @(negedge clk);
    wn = 0; rn = 0;
    req_valid = 1'b1; req_op = op; req_thread = thr;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      if (inject && cyc == 3) begin
        req_valid = 1'b1; req_op = 2'($urandom); req_thread = 3'($urandom);
      end else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [2:0] thr, input bit inject);
    logic [63:0] epc, v, ret, est, tmp;
    logic [15:0] esp, t;
    logic [7:0]  ew [9];
    logic [7:0]  sb;
    int nw, nr, ecyc, cyc;
    string tag;
    v = '0; est = st_m; nw = 0;
    case (op)
      2'd0: begin
        tag = "R2/R3 call";
        v = {1'b1, 31'($urandom), 32'($urandom)};
        for (int i = 0; i < 8; i++) mem[pc_m + 64'(i)] = v[8*i +: 8];
        ret = pc_m + 64'd8;
        for (int j = 0; j < 8; j++) ew[j] = ret[8*(7-j) +: 8];
        nw = 8; nr = 8; ecyc = 17; epc = v; esp = sp_m - 16'd8;
      end
      2'd1: begin
        tag = "R4 return";
        for (int i = 0; i < 8; i++) begin
          t = sp_m + 16'(i + 1); v[8*i +: 8] = mget(stk(t));
        end
        nr = 8; ecyc = 9; epc = v + 64'd1; esp = sp_m + 16'd8;
      end
      2'd2: begin
        tag = "R5/R7 break";
        for (int k = 0; k < 4; k++) begin
          mem[64'hFFE0 + 64'(k)] = 8'($urandom);
          mem[64'hFFF0 + 64'(k)] = 8'($urandom) | ((k == 3) ? 8'h80 : 8'h00);
        end
        for (int k = 0; k < 4; k++) begin
          v[8*k +: 8]      = mget(64'hFFE0 + 64'(k));
          v[32 + 8*k +: 8] = mget(64'hFFF0 + 64'(k));
        end
        tmp = pc_m - 64'd1;
        for (int j = 0; j < 8; j++) ew[j] = tmp[8*(7-j) +: 8];
        ew[8] = st_m[8*thr +: 8];
        est = st_m | (64'h4 << (8*thr));
        nw = 9; nr = 8; ecyc = 18; epc = v; esp = sp_m - 16'd9;
      end
      default: begin
        tag = "R8 return-from-interrupt";
        t = sp_m + 16'd1; sb = mget(stk(t));
        for (int i = 0; i < 8; i++) begin
          t = sp_m + 16'(i + 2); v[8*i +: 8] = mget(stk(t));
        end
        est[8*thr +: 8] = sb;
        nr = 9; ecyc = 10; epc = v + 64'd1; esp = sp_m + 16'd9;
      end
    endcase
    issue(op, thr, inject, cyc);
    check(tag, "pc", pc, epc);
    check(tag, "sp", {48'd0, sp}, {48'd0, esp});
    check({tag, " R6"}, "status lanes", status, est);
    check({tag, " R9"}, "busy cycles", 64'(cyc), 64'(ecyc));
    check({tag, " R9 R10"}, "write count", 64'(wn), 64'(nw));
    check({tag, " R9 R10"}, "read count", 64'(rn), 64'(nr));
    for (int j = 0; j < nw && j < wn; j++) begin
      t = sp_m - 16'(j);
      check({tag, " push"}, $sformatf("write %0d addr", j), wa[j], stk(t));
      check({tag, " push"}, $sformatf("write %0d data", j), {56'd0, wd[j]}, {56'd0, ew[j]});
    end
    pc_m = epc; sp_m = esp; st_m = est;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail_n++;
    $display("FAIL R9 watchdog actual=busy expected=idle");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] p0;
    int cyc;
    void'($urandom(32'd4242));
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_thread = 3'd0;
    mem[64'hFFC0] = 8'h11; mem[64'hFFC1] = 8'h22; mem[64'hFFC2] = 8'h33; mem[64'hFFC3] = 8'h44;
    mem[64'hFFD0] = 8'h55; mem[64'hFFD1] = 8'h66; mem[64'hFFD2] = 8'h77; mem[64'hFFD3] = 8'h88;
    mem[64'hFFC4] = 8'hEE;
    repeat (4) @(negedge clk);
    check("R1", "busy in reset", {63'd0, busy}, 64'd1);
    rst = 1'b0;
    cyc = 0;
    @(negedge clk);
    while (busy) begin cyc++; @(negedge clk); end
    check("R1", "boot pc", pc, 64'h8877_6655_4433_2211);
    check("R1", "boot sp", {48'd0, sp}, 64'h8000);
    check("R1", "boot status", status, 64'd0);
    check("R1 R9", "boot busy cycles", 64'(cyc), 64'd9);
    pc_m = pc; sp_m = 16'h8000; st_m = '0;

    // Call then return lands one past the 8-byte operand.
    p0 = pc_m;
    do_op(2'd0, 3'd0, 1'b0);
    do_op(2'd1, 3'd0, 1'b1);
    check("R4", "call+return lands past operand", pc, p0 + 64'd9);

    // Break on two threads, lane isolation, then interrupt returns.
    do_op(2'd2, 3'd3, 1'b0);
    p0 = pc_m;
    do_op(2'd2, 3'd5, 1'b1);
    do_op(2'd3, 3'd5, 1'b0);
    check("R8", "rti restores pc", pc, p0);
    check("R8", "rti restores lane 5", {56'd0, status[47:40]}, 64'd0);
    @(negedge clk);
    mem[stk(sp_m + 16'd1)] = 8'hA5;
    do_op(2'd3, 3'd3, 1'b0);
    check("R8", "rti loads lane 3", {56'd0, status[31:24]}, 64'hA5);

    for (int n = 0; n < 24; n++)
      do_op(2'($urandom), 3'($urandom), 1'($urandom));

    summary();
    $finish;
  end
endmodule